// File: doc/BRIEF.md
# Serial Transmit Start Controller

This block decides the cycle in which a synchronous serial transmitter begins shifting out a word. It runs in the transmit-clock domain. A four-bit selector picks the trigger: free running, a pulse from the receiver, a compare-match pulse, or a level, an edge or any transition on the frame-sync pin. The frame-sync pin is first passed through a synchronizer. A trigger counts only while a word is waiting in the holding register, transmission is enabled and no transfer is in progress. Once accepted, an optional start delay holds off the one-cycle start-of-data pulse by an exact number of cycles.

The block also divides the transmit clock to produce a periodic frame-sync pulse. It also drives an enable for the transmit clock, which can be gated by the synchronized frame-sync level. The shifter that consumes the start pulse signals the end of each word on `xfer_done`. That returns the block to its idle state, where it waits for the next trigger.

Top module: `txs_start_ctrl`

## Requirements
- R1: `start_sel` chooses the trigger as follows. 0 triggers at once whenever a word is waiting. 1 triggers on `rx_start`. 2 triggers while the synchronized pin is low and 3 while it is high. 4 triggers on a falling edge and 5 on a rising edge. 6 and 7 trigger on any transition. 8 triggers on `cmp_hit`. In mode 0 a new start follows right after `xfer_done` if a word is still waiting.
- R2: A trigger is accepted only when `word_ready` and `tx_en` are both high and the block is idle. From the start pulse until `xfer_done`, no further start occurs, even while a level trigger stays asserted.
- R3: With a start delay of zero, `data_start` rises one cycle after the accepted trigger. With delay D, it rises exactly D cycles later than that, for every selector value. The block never lengthens the delay by itself.
- R4: The start delay applies unchanged when the selector is 1 (receiver start).
- R5: Selector values 9 to 15 never produce a start, whatever the other inputs do.
- R6: `data_start` is one cycle wide. The delay counter reloads from `start_dly` on every accepted trigger.
- R7: A period value of 0 produces no `fs_period` pulse.
- R8: A period value P > 0 produces one `fs_period` pulse every 2×(P+1) cycles.
- R9: `gate_sel` sets `clk_en` as follows. 0 keeps it high. 1 makes it follow the inverted synchronized pin, and 2 the synchronized pin itself. 3 keeps it high.
- R10: The pin passes through two flops. Edges are found by comparing the synchronized sample with the one before it. A pin-based trigger therefore leads to `data_start` on the third clock edge after the pin changes, plus the delay.
- R11: Reset clears the delay counter, the period counter and the edge history. A delay that is counting is abandoned, and the period restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | transmit clock |
| rst_n | input | 1 | active-low reset, asserted asynchronously, released synchronously |
| tx_en | input | 1 | transmission enabled |
| start_sel | input | 4 | trigger selector |
| start_dly | input | DLY_W | start delay in cycles |
| period_sel | input | PER_W | frame-sync period value P |
| gate_sel | input | 2 | clock gating selector |
| fs_pin | input | 1 | frame-sync pin, asynchronous |
| rx_start | input | 1 | receiver start pulse |
| cmp_hit | input | 1 | compare-match pulse |
| word_ready | input | 1 | holding register loaded |
| xfer_done | input | 1 | current word finished |
| data_start | output | 1 | one-cycle start-of-data pulse |
| clk_en | output | 1 | transmit clock enable |
| fs_period | output | 1 | periodic frame-sync pulse |

## Verification
Every selector from 0 to 8 is combined with delays of 0, 1, 2 and 5. The measured latency separates the pulse triggers and free-running mode (one edge) from the pin-based triggers (three edges through the synchronizer). It also shows whether the delay is added exactly. Modes 6 and 7 are tried with rising and falling pins alternately, and the level modes hold their level through the transfer to expose any retrigger. The other patterns are the unused selector codes, a lowered enable, every gating code with both pin levels, periods 0 to 6, and a reset during a long delay.

// File: rtl/txs_pkg.sv
package txs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } txs_state_e;

  localparam logic [3:0] SEL_FREE     = 4'd0;
  localparam logic [3:0] SEL_RX       = 4'd1;
  localparam logic [3:0] SEL_LOW      = 4'd2;
  localparam logic [3:0] SEL_HIGH     = 4'd3;
  localparam logic [3:0] SEL_FALL     = 4'd4;
  localparam logic [3:0] SEL_RISE     = 4'd5;
  localparam logic [3:0] SEL_CHANGE_A = 4'd6;
  localparam logic [3:0] SEL_CHANGE_B = 4'd7;
  localparam logic [3:0] SEL_CMP      = 4'd8;

  localparam logic [1:0] GATE_NONE = 2'd0;
  localparam logic [1:0] GATE_LOW  = 2'd1;
  localparam logic [1:0] GATE_HIGH = 2'd2;

endpackage

// File: rtl/txs_fs_sync.sv
module txs_fs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_pin,
  output logic fs_lvl,
  output logic fs_rise,
  output logic fs_fall
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              hist_q;
  logic              hist_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], fs_pin};
    hist_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  assign fs_lvl  = sync_q[STAGES-1];
  assign fs_rise = sync_q[STAGES-1] & ~hist_q;
  assign fs_fall = ~sync_q[STAGES-1] & hist_q;

  // R10: an edge is reported for a single cycle only
  p_rise_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fs_rise |=> !fs_rise);
  p_fall_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fs_fall |=> !fs_fall);

endmodule

// File: rtl/txs_start_fsm.sv
module txs_start_fsm
  import txs_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [3:0]       start_sel,
  input  logic [DLY_W-1:0] start_dly,
  input  logic             rx_start,
  input  logic             cmp_hit,
  input  logic             word_ready,
  input  logic             xfer_done,
  input  logic             fs_lvl,
  input  logic             fs_rise,
  input  logic             fs_fall,
  output logic             data_start
);

  localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

  txs_state_e       state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             start_q, start_d;
  logic             cond;
  logic             accept;

  always_comb begin
    case (start_sel)
      SEL_FREE:     cond = 1'b1;
      SEL_RX:       cond = rx_start;
      SEL_LOW:      cond = ~fs_lvl;
      SEL_HIGH:     cond = fs_lvl;
      SEL_FALL:     cond = fs_fall;
      SEL_RISE:     cond = fs_rise;
      SEL_CHANGE_A: cond = fs_rise | fs_fall;
      SEL_CHANGE_B: cond = fs_rise | fs_fall;
      SEL_CMP:      cond = cmp_hit;
      default:      cond = 1'b0;
    endcase
  end

  assign accept = word_ready & tx_en & cond;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    start_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (start_dly == '0) begin
            start_d = 1'b1;
            state_d = ST_RUN;
          end else begin
            cnt_d   = start_dly;
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (cnt_q <= DLY_ONE) begin
          start_d = 1'b1;
          cnt_d   = '0;
          state_d = ST_RUN;
        end else begin
          cnt_d = cnt_q - DLY_ONE;
        end
      end
      ST_RUN: begin
        if (xfer_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
    end
  end

  assign data_start = start_q;

  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |=> !data_start);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && $past(state_q) == ST_IDLE) |-> cnt_q == $past(start_dly));

  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && cnt_q > DLY_ONE) |=>
      (state_q == ST_WAIT && cnt_q == $past(cnt_q) - DLY_ONE));

  p_need_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !(word_ready && tx_en)) |=> (state_q == ST_IDLE && !data_start));

  p_busy_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !xfer_done) |=> !data_start);

  p_unused_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_sel > SEL_CMP) |=> state_q == ST_IDLE);

endmodule

// File: rtl/txs_period_gen.sv
module txs_period_gen #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_sel,
  output logic             fs_period
);

  localparam int CW = PER_W + 2;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] last;
  logic          en;

  assign en   = (period_sel != '0);
  assign last = {1'b0, period_sel, 1'b1};

  always_comb begin
    if (!en)                cnt_d = '0;
    else if (cnt_q >= last) cnt_d = '0;
    else                    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fs_period = en & (cnt_q == last);

  p_hold_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (period_sel == '0) |=> (cnt_q == '0 && !fs_period));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fs_period |=> cnt_q == '0);

endmodule

// File: rtl/txs_start_ctrl.sv
module txs_start_ctrl
  import txs_pkg::*;
#(
  parameter int DLY_W       = 8,
  parameter int PER_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic [3:0]       start_sel,
  input  logic [DLY_W-1:0] start_dly,
  input  logic [PER_W-1:0] period_sel,
  input  logic [1:0]       gate_sel,
  input  logic             fs_pin,
  input  logic             rx_start,
  input  logic             cmp_hit,
  input  logic             word_ready,
  input  logic             xfer_done,
  output logic             data_start,
  output logic             clk_en,
  output logic             fs_period
);

  logic fs_lvl;
  logic fs_rise;
  logic fs_fall;

  txs_fs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .fs_pin  (fs_pin),
    .fs_lvl  (fs_lvl),
    .fs_rise (fs_rise),
    .fs_fall (fs_fall)
  );

  txs_start_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .start_sel  (start_sel),
    .start_dly  (start_dly),
    .rx_start   (rx_start),
    .cmp_hit    (cmp_hit),
    .word_ready (word_ready),
    .xfer_done  (xfer_done),
    .fs_lvl     (fs_lvl),
    .fs_rise    (fs_rise),
    .fs_fall    (fs_fall),
    .data_start (data_start)
  );

  txs_period_gen #(.PER_W(PER_W)) u_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_sel (period_sel),
    .fs_period  (fs_period)
  );

  always_comb begin
    case (gate_sel)
      GATE_LOW:  clk_en = ~fs_lvl;
      GATE_HIGH: clk_en = fs_lvl;
      default:   clk_en = 1'b1;
    endcase
  end

  p_gate_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_sel == GATE_NONE) |-> clk_en);

  p_gate_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_sel == GATE_LOW && $rose(fs_lvl)) |-> !clk_en);

endmodule

// File: tb/txs_start_ctrl_test.sv
module txs_start_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en;
  logic [3:0] start_sel;
  logic [7:0] start_dly;
  logic [7:0] period_sel;
  logic [1:0] gate_sel;
  logic       fs_pin;
  logic       rx_start;
  logic       cmp_hit;
  logic       word_ready;
  logic       xfer_done;
  logic       data_start;
  logic       clk_en;
  logic       fs_period;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  txs_start_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .start_sel(start_sel),
    .start_dly(start_dly), .period_sel(period_sel), .gate_sel(gate_sel),
    .fs_pin(fs_pin), .rx_start(rx_start), .cmp_hit(cmp_hit),
    .word_ready(word_ready), .xfer_done(xfer_done),
    .data_start(data_start), .clk_en(clk_en), .fs_period(fs_period)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_start(input int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      rx_start = 1'b0;
      cmp_hit  = 1'b0;
      if (data_start) begin
        k = i;
        break;
      end
    end
  endtask

  task automatic end_xfer();
    word_ready = 1'b0;
    xfer_done  = 1'b1;
    @(negedge clk);
    xfer_done  = 1'b0;
    check(data_start == 1'b0, "R6 pulse width", int'(data_start), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int dlys[4];
    int k, base, d, seen, first;
    bit inact;
    dlys[0] = 0; dlys[1] = 1; dlys[2] = 2; dlys[3] = 5;

    rst_n = 1'b0; tx_en = 1'b1; start_sel = 4'd0; start_dly = 8'd0;
    period_sel = 8'd2; gate_sel = 2'd0; fs_pin = 1'b0; rx_start = 1'b0;
    cmp_hit = 1'b0; word_ready = 1'b0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    check(data_start == 1'b0, "R11 reset start", int'(data_start), 0);
    check(fs_period == 1'b0, "R11 reset period", int'(fs_period), 0);
    check(clk_en == 1'b1, "R11 reset clk_en", int'(clk_en), 1);
    rst_n = 1'b1;
    period_sel = 8'd0;

    // selector x delay sweep (R1 R3 R4 R10)
    for (int sel = 0; sel <= 8; sel++) begin
      for (int di = 0; di < 4; di++) begin
        d = dlys[di];
        word_ready = 1'b0;
        start_sel  = 4'(sel);
        start_dly  = 8'(d);
        case (sel)
          2, 4:    inact = 1'b1;
          6, 7:    inact = 1'(di % 2);
          default: inact = 1'b0;
        endcase
        fs_pin = inact;
        repeat (5) @(negedge clk);
        if (sel != 0) begin
          word_ready = 1'b1;
          seen = 0;
          repeat (3) begin
            @(negedge clk);
            if (data_start) seen++;
          end
          check(seen == 0, "R1 no start before trigger", seen, 0);
        end
        case (sel)
          0:       begin word_ready = 1'b1; base = 1; end
          1:       begin rx_start = 1'b1; base = 1; end
          8:       begin cmp_hit = 1'b1; base = 1; end
          default: begin fs_pin = ~inact; base = 3; end
        endcase
        wait_start(40, k);
        if (sel == 1)
          check(k == base + d, "R4 R3 receiver-start latency", k, base + d);
        else if (base == 3)
          check(k == base + d, "R1 R3 R10 pin-trigger latency", k, base + d);
        else
          check(k == base + d, "R1 R3 start latency", k, base + d);
        if (sel == 2 || sel == 3) begin
          seen = 0;
          repeat (8) begin
            @(negedge clk);
            if (data_start) seen++;
          end
          check(seen == 0, "R2 no retrigger while busy", seen, 0);
        end
        end_xfer();
      end
    end

    // continuous mode restarts right after xfer_done (R1)
    start_sel = 4'd0; start_dly = 8'd0; fs_pin = 1'b0;
    word_ready = 1'b1;
    wait_start(10, k);
    check(k == 1, "R1 continuous first", k, 1);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check(data_start == 1'b0, "R1 continuous gap", int'(data_start), 0);
    @(negedge clk);
    check(data_start == 1'b1, "R1 continuous restart", int'(data_start), 1);
    end_xfer();

    // transmit disabled (R2)
    tx_en = 1'b0;
    word_ready = 1'b1;
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (data_start) seen++;
    end
    check(seen == 0, "R2 disabled", seen, 0);
    tx_en = 1'b1;
    wait_start(10, k);
    check(k == 1, "R2 enable restores", k, 1);
    end_xfer();

    // unused selector codes (R5)
    for (int sel = 9; sel <= 15; sel++) begin
      start_sel = 4'(sel);
      word_ready = 1'b1;
      seen = 0;
      for (int c = 0; c < 14; c++) begin
        rx_start = (c == 1);
        cmp_hit  = (c == 2);
        fs_pin   = (c >= 4 && c < 9);
        @(negedge clk);
        if (data_start) seen++;
      end
      rx_start = 1'b0; cmp_hit = 1'b0;
      check(seen == 0, "R5 unused selector", seen, 0);
      word_ready = 1'b0;
      @(negedge clk);
    end

    // clock gating (R9)
    for (int g = 0; g < 4; g++) begin
      for (int l = 0; l < 2; l++) begin
        int exp;
        gate_sel = 2'(g);
        fs_pin   = 1'(l);
        repeat (3) @(negedge clk);
        exp = (g == 1) ? 1 - l : (g == 2) ? l : 1;
        check(int'(clk_en) == exp, "R9 gating", int'(clk_en), exp);
      end
    end
    gate_sel = 2'd0;

    // period generation (R7 R8)
    for (int p = 0; p <= 6; p++) begin
      period_sel = 8'(p);
      if (p == 0) begin
        @(negedge clk);
        seen = 0;
        repeat (40) begin
          @(negedge clk);
          if (fs_period) seen++;
        end
        check(seen == 0, "R7 period off", seen, 0);
      end else begin
        first = 0;
        for (int i = 1; i <= 40; i++) begin
          @(negedge clk);
          if (fs_period) begin first = i; break; end
        end
        for (int rep = 0; rep < 2; rep++) begin
          k = 0;
          for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (fs_period) begin k = i; break; end
          end
          check(first != 0 && k == 2 * (p + 1), "R8 period interval", k, 2 * (p + 1));
        end
      end
    end

    // reset during a long delay (R11)
    period_sel = 8'd3;
    start_sel = 4'd0; start_dly = 8'd20; word_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b0; word_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    seen = 0; first = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (data_start) seen++;
      if (fs_period && first == 0) first = i;
    end
    check(seen == 0, "R11 delay abandoned", seen, 0);
    check(first == 7, "R11 period restarts", first, 7);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule